// File: doc/BRIEF.md
# Parallel CPU-Bus Panel Write Engine

This block writes a frame of pixel words into the internal frame memory of a smart panel over an 8080-style parallel write bus. Software programs four strobe timing nibbles, the frame width and the frame height through a small register write port. It then issues a trigger command. From that point the engine pulls pixel words from a valid/ready stream and drives each word onto the data bus under its own write strobe, with chip select held low for the whole frame. When the last pixel has been written, the engine releases chip select and raises a one-clock frame-done pulse.

A frame transfer starts only on a trigger command, so no frame is ever launched on its own. While a transfer is running, any further trigger is dropped, because a repeated trigger can reset the panel. A sticky done flag records each finished frame until software clears it.

Top module: `pbw_panel_writer`

## Requirements
- R1: After reset, lcd_cs_n and lcd_wr_n are 1, lcd_rs is 0, frame_done and done_flag are 0 and pix_ready is 0.
- R2: A write to address 0 loads the timing word. Bits 19:16 hold the chip-select setup (CSS), bits 15:12 the write setup (WRS), bits 11:8 the write-active width (ACT), bits 7:4 the write hold (HLD) and bit 0 the interface enable. At reset the four fields are 0, 0, 1 and 0 and the enable is 0.
- R3: A write to address 1 starts a frame only when wdata bit 0 (bus mode) and bit 1 (go) are both 1 and the interface enable is 1. Any other trigger write leaves lcd_cs_n high, produces no strobe and produces no done pulse.
- R4: Take a pixel accepted in clock n. lcd_wr_n falls at the edge that ends clock n+CSS+WRS. It stays low for ACT' clocks, where ACT' = max(ACT,1). It then stays high for at least HLD+1 clocks. When data is always available, consecutive falling edges are CSS+WRS+ACT'+HLD+1 clocks apart.
- R5: An ACT field of 0 gives a strobe that is one clock wide.
- R6: lcd_data carries the accepted pixel word from the clock after acceptance through the rising edge of its strobe. The words reach the bus in stream order.
- R7: Address 2 holds the width and address 3 holds the height (bits DIM_W-1:0). A frame accepts exactly width*height pixels and produces exactly width*height write strobes.
- R8: A trigger written while a frame is in progress is ignored. The frame still writes exactly width*height pixels and produces one done pulse.
- R9: While the stream has no valid word during a frame, lcd_cs_n stays 0, lcd_wr_n stays 1 and no strobe is issued.
- R10: lcd_wr_n is low only while lcd_cs_n is low and lcd_rs is 1. When the last write cycle ends, frame_done goes high for exactly one clock and lcd_cs_n returns to 1.
- R11: done_flag is set by each frame end. Writing 1 in bit 0 at address 4 clears it. Writing 0 there leaves it set.
- R12: A frame with width or height 0 ends with a single done pulse and no strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Engine takes the pixel word this clock |
| pix_data | input | DATA_W | Pixel word |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_rs | output | 1 | Register/data select, 1 for pixel data |
| lcd_data | output | DATA_W | Panel data bus |
| frame_done | output | 1 | One-clock pulse when a frame ends |
| done_flag | output | 1 | Sticky frame-end flag |

## Verification
The hardest condition to reach is a trigger that arrives while a frame is still being written. The stimulus programs a 16-pixel frame and issues a second trigger a few clocks after the first. It then checks that the total strobe count and the done count both match a single frame. Another hard condition is an empty stream inside an active frame. The bench reaches it by holding the source off while it triggers, then watches the bus stay parked before it releases the data. The strobe phase arithmetic is checked by measuring the distance from acceptance to the falling edge, the low width and the fall-to-fall period under several timing words, including one with a zero active width.

// File: rtl/pbw_pkg.sv
package pbw_pkg;
  localparam int NIB_W = 4;

  localparam logic [2:0] ADDR_CFG    = 3'd0;
  localparam logic [2:0] ADDR_TRIG   = 3'd1;
  localparam logic [2:0] ADDR_WIDTH  = 3'd2;
  localparam logic [2:0] ADDR_HEIGHT = 3'd3;
  localparam logic [2:0] ADDR_STAT   = 3'd4;

  localparam int TRIG_MODE_BIT = 0;
  localparam int TRIG_GO_BIT   = 1;

  typedef struct packed {
    logic [NIB_W-1:0] cs_setup;
    logic [NIB_W-1:0] wr_setup;
    logic [NIB_W-1:0] wr_active;
    logic [NIB_W-1:0] wr_hold;
  } strobe_timing_t;
endpackage

// File: rtl/pbw_regs.sv
module pbw_regs
  import pbw_pkg::*;
#(
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [2:0]       addr,
  input  logic [31:0]      wdata,
  input  logic             done_evt,
  output strobe_timing_t   timing,
  output logic             if_en,
  output logic             trig_cmd,
  output logic [DIM_W-1:0] width,
  output logic [DIM_W-1:0] height,
  output logic             done_flag
);
  logic unused_wdata;
  assign unused_wdata = ^{wdata[31:20], wdata[3:2]};

  assign trig_cmd = we && (addr == ADDR_TRIG) && wdata[TRIG_MODE_BIT] &&
                    wdata[TRIG_GO_BIT] && if_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      timing.cs_setup  <= '0;
      timing.wr_setup  <= '0;
      timing.wr_active <= NIB_W'(1);
      timing.wr_hold   <= '0;
      if_en            <= 1'b0;
      width            <= '0;
      height           <= '0;
      done_flag        <= 1'b0;
    end else begin
      if (we && addr == ADDR_CFG) begin
        timing.cs_setup  <= wdata[19:16];
        timing.wr_setup  <= wdata[15:12];
        timing.wr_active <= wdata[11:8];
        timing.wr_hold   <= wdata[7:4];
        if_en            <= wdata[0];
      end
      if (we && addr == ADDR_WIDTH)  width  <= wdata[DIM_W-1:0];
      if (we && addr == ADDR_HEIGHT) height <= wdata[DIM_W-1:0];
      if (done_evt)
        done_flag <= 1'b1;
      else if (we && addr == ADDR_STAT && wdata[0])
        done_flag <= 1'b0;
    end
  end

  assert_flag_sets_R11: assert property (@(posedge clk) disable iff (rst)
    done_evt |=> done_flag);
endmodule

// File: rtl/pbw_frame_ctl.sv
module pbw_frame_ctl #(
  parameter int DIM_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig_cmd,
  input  logic [DIM_W-1:0] width,
  input  logic [DIM_W-1:0] height,
  input  logic             accept,
  input  logic             engine_idle,
  input  logic             cycle_end,
  output logic             active,
  output logic             pix_left_nz,
  output logic             cs_n,
  output logic             rs,
  output logic             done
);
  localparam int CNT_W = 2 * DIM_W;

  logic [CNT_W-1:0] remaining;

  assign pix_left_nz = (remaining != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      active    <= 1'b0;
      remaining <= '0;
      cs_n      <= 1'b1;
      rs        <= 1'b0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        if (trig_cmd) begin
          active    <= 1'b1;
          remaining <= CNT_W'(width) * CNT_W'(height);
          cs_n      <= 1'b0;
          rs        <= 1'b1;
        end
      end else begin
        if (accept) remaining <= remaining - 1'b1;
        if (!pix_left_nz && (engine_idle || cycle_end)) begin
          done   <= 1'b1;
          active <= 1'b0;
          cs_n   <= 1'b1;
          rs     <= 1'b0;
        end
      end
    end
  end

  assert_done_single_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  assert_retrig_no_reload_R8: assert property (@(posedge clk) disable iff (rst)
    (active && trig_cmd) |=> (remaining <= $past(remaining)));
  assert_no_accept_idle_R7: assert property (@(posedge clk) disable iff (rst)
    accept |-> (active && pix_left_nz));
endmodule

// File: rtl/pbw_strobe.sv
module pbw_strobe
  import pbw_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  strobe_timing_t    timing,
  input  logic              frame_active,
  input  logic              pix_left_nz,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              accept,
  output logic              cycle_end,
  output logic              idle,
  output logic              wr_n,
  output logic [DATA_W-1:0] data
);
  localparam int TW = $clog2(4 * (2 ** NIB_W) + 1);

  logic          busy;
  logic [TW-1:0] t;
  logic [TW-1:0] act_len, lead, total, t_inc;
  logic          inc_low;

  always_comb begin
    act_len = (timing.wr_active == '0) ? TW'(1) : TW'(timing.wr_active);
    lead    = TW'(timing.cs_setup) + TW'(timing.wr_setup);
    total   = lead + act_len + TW'(timing.wr_hold) + TW'(1);
    t_inc   = t + TW'(1);
    inc_low = (t_inc >= lead) && (t_inc < lead + act_len);
  end

  assign idle      = !busy;
  assign cycle_end = busy && (t == total - TW'(1));
  assign pix_ready = frame_active && pix_left_nz && (!busy || cycle_end);
  assign accept    = pix_ready && pix_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      t    <= '0;
      wr_n <= 1'b1;
      data <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      t    <= '0;
      data <= pix_data;
      wr_n <= (lead != '0);
    end else if (cycle_end) begin
      busy <= 1'b0;
      wr_n <= 1'b1;
    end else if (busy) begin
      t    <= t_inc;
      wr_n <= !inc_low;
    end
  end

  assert_data_held_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> $stable(data));
  assert_no_strobe_without_data_R9: assert property (@(posedge clk) disable iff (rst)
    (idle && !pix_valid) |=> wr_n);
endmodule

// File: rtl/pbw_panel_writer.sv
module pbw_panel_writer
  import pbw_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic              lcd_rs,
  output logic [DATA_W-1:0] lcd_data,
  output logic              frame_done,
  output logic              done_flag
);
  strobe_timing_t   timing;
  logic             if_en, trig_cmd;
  logic [DIM_W-1:0] width, height;
  logic             active, pix_left_nz, accept, engine_idle, cycle_end;
  logic             unused_en;

  assign unused_en = if_en;

  pbw_regs #(.DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .done_evt(frame_done), .timing(timing), .if_en(if_en), .trig_cmd(trig_cmd),
    .width(width), .height(height), .done_flag(done_flag)
  );

  pbw_frame_ctl #(.DIM_W(DIM_W)) u_frame (
    .clk(clk), .rst(rst), .trig_cmd(trig_cmd), .width(width), .height(height),
    .accept(accept), .engine_idle(engine_idle), .cycle_end(cycle_end),
    .active(active), .pix_left_nz(pix_left_nz), .cs_n(lcd_cs_n), .rs(lcd_rs),
    .done(frame_done)
  );

  pbw_strobe #(.DATA_W(DATA_W)) u_strobe (
    .clk(clk), .rst(rst), .timing(timing), .frame_active(active),
    .pix_left_nz(pix_left_nz), .pix_valid(pix_valid), .pix_data(pix_data),
    .pix_ready(pix_ready), .accept(accept), .cycle_end(cycle_end),
    .idle(engine_idle), .wr_n(lcd_wr_n), .data(lcd_data)
  );

  assert_wr_inside_cs_R10: assert property (@(posedge clk) disable iff (rst)
    !lcd_wr_n |-> (!lcd_cs_n && lcd_rs));
  assert_ready_needs_cs_R9: assert property (@(posedge clk) disable iff (rst)
    pix_ready |-> !lcd_cs_n);
endmodule

// File: tb/test_pbw_panel_writer.sv
module test_pbw_panel_writer;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 16;
  localparam int BASE = 16'h1000;

  logic clk = 0, rst = 1;
  logic reg_we = 0;
  logic [2:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic pix_valid = 0;
  logic [DATA_W-1:0] pix_data = 0;
  logic pix_ready, lcd_cs_n, lcd_wr_n, lcd_rs, frame_done, done_flag;
  logic [DATA_W-1:0] lcd_data;

  int checks = 0, fails = 0;
  bit finished = 0;
  bit src_en = 0;
  int fidx = 0;

  int cyc = 0, n_fall, n_rise, n_acc, n_done, cur_low, min_low, max_low;
  int last_fall, min_int, max_int, first_fall, first_acc, done_run, max_done_run;
  int cs_bad, rs_bad;
  logic prev_wr = 1;
  logic [DATA_W-1:0] cap [0:63];

  always #(CLK_PERIOD/2) clk = ~clk;

  pbw_panel_writer #(.DATA_W(DATA_W), .DIM_W(10)) i_pbw_panel_writer (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .lcd_cs_n(lcd_cs_n), .lcd_wr_n(lcd_wr_n), .lcd_rs(lcd_rs), .lcd_data(lcd_data),
    .frame_done(frame_done), .done_flag(done_flag)
  );

  // pixel source
  initial begin
    bit acc;
    forever begin
      @(negedge clk);
      acc = pix_valid && pix_ready;
      @(posedge clk);
      #1;
      if (acc) fidx++;
      pix_data  = DATA_W'(BASE + fidx);
      pix_valid = src_en;
    end
  end

  // bus monitor
  always @(negedge clk) begin
    cyc++;
    if (pix_valid && pix_ready) begin
      if (n_acc == 0) first_acc = cyc;
      n_acc++;
    end
    if (!lcd_wr_n) begin
      cur_low++;
      if (lcd_cs_n) cs_bad++;
      if (!lcd_rs) rs_bad++;
    end
    if (prev_wr && !lcd_wr_n) begin
      if (n_fall == 0) first_fall = cyc;
      else begin
        if (cyc - last_fall < min_int) min_int = cyc - last_fall;
        if (cyc - last_fall > max_int) max_int = cyc - last_fall;
      end
      last_fall = cyc;
      n_fall++;
    end
    if (!prev_wr && lcd_wr_n) begin
      if (n_rise < 64) cap[n_rise] = lcd_data;
      n_rise++;
      if (cur_low < min_low) min_low = cur_low;
      if (cur_low > max_low) max_low = cur_low;
      cur_low = 0;
    end
    if (frame_done) begin
      done_run++;
      if (done_run > max_done_run) max_done_run = done_run;
    end else done_run = 0;
    if (frame_done && done_run == 1) n_done++;
    prev_wr = lcd_wr_n;
  end

  task automatic clear_meas();
    @(negedge clk);
    n_fall = 0; n_rise = 0; n_acc = 0; n_done = 0; cur_low = 0;
    min_low = 1000; max_low = 0; min_int = 1000; max_int = 0;
    first_fall = 0; first_acc = 0; done_run = 0; max_done_run = 0;
    cs_bad = 0; rs_bad = 0;
  endtask

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(logic [2:0] a, logic [31:0] d);
    @(posedge clk); #1;
    reg_we = 1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic wait_done(string req);
    int k;
    k = 0;
    while (n_done == 0 && k < 3000) begin @(negedge clk); k++; end
    check(req, int'(n_done != 0), 1, "frame ended");
    repeat (20) @(negedge clk);
  endtask

  task automatic setup_frame(logic [31:0] cfg, int w, int h);
    wr_reg(3'd0, cfg);
    wr_reg(3'd2, w);
    wr_reg(3'd3, h);
  endtask

  function automatic logic [31:0] tword(int css, int wrs, int act, int hld);
    return (32'(css) << 16) | (32'(wrs) << 12) | (32'(act) << 8) | (32'(hld) << 4) | 32'h1;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    check("R1", lcd_cs_n, 1, "cs_n after reset");
    check("R1", lcd_wr_n, 1, "wr_n after reset");
    check("R1", lcd_rs, 0, "rs after reset");
    check("R1", frame_done, 0, "frame_done after reset");
    check("R1", done_flag, 0, "done_flag after reset");
    check("R1", pix_ready, 0, "pix_ready after reset");
  endtask

  task automatic t_no_enable();
    src_en = 1;
    setup_frame(32'h0000_0100, 2, 2);
    clear_meas();
    wr_reg(3'd1, 32'h3);
    repeat (30) @(negedge clk);
    check("R3", n_fall, 0, "strobes with interface disabled");
    check("R3", lcd_cs_n, 1, "cs_n with interface disabled");
    check("R3", n_done, 0, "done with interface disabled");
  endtask

  task automatic t_partial_trig();
    setup_frame(tword(0, 0, 1, 0), 2, 2);
    clear_meas();
    wr_reg(3'd1, 32'h2);
    wr_reg(3'd1, 32'h1);
    repeat (30) @(negedge clk);
    check("R3", n_fall, 0, "strobes after half trigger");
    check("R3", n_done, 0, "done after half trigger");
  endtask

  task automatic run_frame(string req, logic [31:0] cfg, int w, int h, int exp_setup,
                           int exp_low, int exp_int);
    int start, bad;
    setup_frame(cfg, w, h);
    clear_meas();
    start = fidx;
    wr_reg(3'd1, 32'h3);
    wait_done(req);
    check(req, n_fall, w * h, "strobe count");
    check(req, n_acc, w * h, "accepted pixels");
    check(req, first_fall - first_acc, exp_setup, "accept-to-fall clocks");
    check(req, min_low, exp_low, "min strobe low width");
    check(req, max_low, exp_low, "max strobe low width");
    check(req, min_int, exp_int, "min fall-to-fall period");
    check(req, max_int, exp_int, "max fall-to-fall period");
    bad = 0;
    for (int i = 0; i < n_rise && i < 64; i++)
      if (cap[i] != DATA_W'(BASE + start + i)) bad++;
    check("R6", bad, 0, "pixel words out of order");
    check("R10", n_done, 1, "done pulses");
    check("R10", max_done_run, 1, "done pulse width");
    check("R10", lcd_cs_n, 1, "cs_n after frame");
    check("R10", cs_bad + rs_bad, 0, "strobe outside cs/rs");
  endtask

  task automatic t_default();
    src_en = 1;
    run_frame("R7", tword(0, 0, 1, 0), 3, 2, 1, 1, 2);
  endtask

  task automatic t_custom();
    run_frame("R4", tword(2, 1, 3, 2), 2, 2, 4, 3, 9);
    run_frame("R2", tword(0, 3, 2, 0), 2, 1, 4, 2, 6);
  endtask

  task automatic t_act_zero();
    run_frame("R5", tword(1, 0, 0, 0), 2, 2, 2, 1, 3);
  endtask

  task automatic t_retrigger();
    setup_frame(tword(0, 0, 1, 0), 4, 4);
    clear_meas();
    wr_reg(3'd1, 32'h3);
    repeat (5) @(negedge clk);
    wr_reg(3'd1, 32'h3);
    wait_done("R8");
    repeat (40) @(negedge clk);
    check("R8", n_fall, 16, "strobes with retrigger");
    check("R8", n_done, 1, "done pulses with retrigger");
  endtask

  task automatic t_stall();
    src_en = 0;
    setup_frame(tword(0, 0, 1, 0), 4, 1);
    repeat (3) @(negedge clk);
    clear_meas();
    wr_reg(3'd1, 32'h3);
    repeat (20) @(negedge clk);
    check("R9", n_fall, 0, "strobes while stream empty");
    check("R9", lcd_cs_n, 0, "cs_n while stream empty");
    check("R9", lcd_wr_n, 1, "wr_n while stream empty");
    src_en = 1;
    wait_done("R9");
    check("R9", n_fall, 4, "strobes after stream resumes");
  endtask

  task automatic t_sticky();
    wr_reg(3'd4, 32'h1);
    @(negedge clk);
    check("R11", done_flag, 0, "flag after clear");
    setup_frame(tword(0, 0, 1, 0), 1, 2);
    clear_meas();
    wr_reg(3'd1, 32'h3);
    wait_done("R11");
    check("R11", done_flag, 1, "flag after frame");
    wr_reg(3'd4, 32'h0);
    @(negedge clk);
    check("R11", done_flag, 1, "flag after writing 0");
    wr_reg(3'd4, 32'h1);
    @(negedge clk);
    check("R11", done_flag, 0, "flag after writing 1");
  endtask

  task automatic t_zero();
    setup_frame(tword(0, 0, 1, 0), 0, 5);
    clear_meas();
    wr_reg(3'd1, 32'h3);
    wait_done("R12");
    check("R12", n_fall, 0, "strobes in empty frame");
    check("R12", n_done, 1, "done pulses in empty frame");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_meas();
    repeat (4) @(posedge clk);
    #1 rst = 0;
    t_reset();
    t_no_enable();
    t_partial_trig();
    t_default();
    t_custom();
    t_act_zero();
    t_retrigger();
    t_stall();
    t_sticky();
    t_zero();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule